// File: doc/BRIEF.md
# Ten-Channel Serial Bridge for a 16-bit Parallel Host

This block lets a host with a single 16-bit parallel port drive ten independent asynchronous serial lines. When the host writes a word, its low byte is the character and bits 11:8 name the channel that sends it. That channel's transmitter shifts out one frame: a start bit, then eight data bits with the LSB first, then one stop bit. The line idles high.

Every receiver watches its own line with a tick at sixteen times the baud rate. The tick comes from one shared divider, and the host sets that divider through the `os_div` input. A receiver confirms a start bit at the middle of the bit and samples each data bit at its centre. It then holds the finished character in a one-deep slot. While any slot holds a character, the interrupt line stays high. The read port shows the character from the lowest-numbered pending channel, together with that channel's index and its error flags. The host reads that word and then pulses the read strobe, which frees the slot.

Top module: `mux_uart_bridge`

## Requirements
- R1: After reset every `tx` line is high, `irq` is low and bit 14 of `rd_data` is 0.
- R2: A write with `wr_data[11:8]` below 10 to an idle channel sends `wr_data[7:0]` on that channel's `tx` line as 0, then the eight data bits LSB first, then 1. No other `tx` line moves.
- R3: A write with `wr_data[11:8]` of 10 or more starts no frame on any line and does not set the busy-error bit.
- R4: A write to a channel that is still sending is dropped, and the frame in progress continues unchanged. The write sets the sticky busy-error flag, which shows as bit 14 of `rd_data`. Any pulse of `rd_en` clears that flag.
- R5: Each serial bit lasts 16 ticks, and one tick is `os_div`+1 clock cycles. Both transmit and receive use this bit time.
- R6: A received frame makes its channel pending. `rd_data` then shows the character in bits 7:0, the channel index in bits 11:8, the framing-error flag in bit 12 and the overrun flag in bit 13. Bit 15 is 0.
- R7: `irq` is high exactly while at least one channel is pending. A pulse of `rd_en` while `irq` is high clears the channel currently shown on `rd_data`.
- R8: When several channels are pending, `rd_data` shows the lowest channel index first.
- R9: A frame whose stop bit samples low is still delivered, with bit 12 set. The receiver does not accept a new start bit until its line has been seen high again.
- R10: A frame that completes while its channel is still pending replaces the held character and sets bit 13.
- R11: A low pulse that is gone by the middle of the start bit is discarded and produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_div | input | DIVW | Tick period minus one, in clock cycles |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write word: channel in bits 11:8, character in bits 7:0 |
| rd_en | input | 1 | Host read strobe; acknowledges the word shown on `rd_data` |
| rd_data | output | 16 | Receive word for the lowest pending channel |
| irq | output | 1 | High while any character is pending |
| rx | input | NCH | Serial input lines |
| tx | output | NCH | Serial output lines |

## Verification
The assertions assume that the host strobes are single-cycle pulses. They also assume that `os_div` stays fixed while a frame is in flight, and that `rd_en` is treated as an acknowledgement of the word shown just before it. The bench drives strobes for exactly one cycle and changes `os_div` only while every line is idle. Its serial stimulus is aligned to whole bit times at the programmed rate. On concurrent receive lines the bench starts frames in the same cycle, so the priority order is tested with two characters pending at once.

// File: rtl/mux_uart_bridge.sv
module mux_uart_bridge #(
  parameter int NCH  = 10,
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] os_div,
  input  logic            wr_en,
  input  logic [15:0]     wr_data,
  input  logic            rd_en,
  output logic [15:0]     rd_data,
  output logic            irq,
  input  logic [NCH-1:0]  rx,
  output logic [NCH-1:0]  tx
);

  logic [DIVW-1:0] dcnt;
  logic            tick;
  assign tick = (dcnt >= os_div);

  always_ff @(posedge clk)
    if (!rst_n) dcnt <= '0;
    else        dcnt <= tick ? '0 : dcnt + 1'b1;

  logic [3:0] wr_ch;
  logic       wr_ok;
  assign wr_ch = wr_data[11:8];
  assign wr_ok = wr_en && (int'(wr_ch) < NCH);

  logic [NCH-1:0] tx_busy, drop_v, rx_done, pend, ferr, ovr;
  logic [7:0]     hold [NCH];
  logic [3:0]     sel;
  logic           busy_err, rd_clr;

  assign irq    = |pend;
  assign rd_clr = rd_en && irq;

  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) sel = 4'(i);
  end

  assign rd_data = {1'b0, busy_err, ovr[sel], ferr[sel], sel, hold[sel]};

  always_ff @(posedge clk)
    if (!rst_n)     busy_err <= 1'b0;
    else if (|drop_v) busy_err <= 1'b1;
    else if (rd_en) busy_err <= 1'b0;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [9:0] tsh;
    logic [3:0] tsub, tbit;
    logic       take;
    assign take      = wr_ok && (wr_ch == 4'(g));
    assign drop_v[g] = take && tx_busy[g];
    assign tx[g]     = tx_busy[g] ? tsh[0] : 1'b1;

    always_ff @(posedge clk)
      if (!rst_n) begin
        tx_busy[g] <= 1'b0;
        tsh <= '1; tsub <= '0; tbit <= '0;
      end else if (take && !tx_busy[g]) begin
        tx_busy[g] <= 1'b1;
        tsh <= {1'b1, wr_data[7:0], 1'b0};
        tsub <= '0; tbit <= '0;
      end else if (tx_busy[g] && tick) begin
        tsub <= tsub + 1'b1;
        if (tsub == 4'd15) begin
          tsh  <= {1'b1, tsh[9:1]};
          tbit <= tbit + 1'b1;
          if (tbit == 4'd9) tx_busy[g] <= 1'b0;
        end
      end

    logic [1:0] sync;
    logic       act, arm, line;
    logic [3:0] rsub, rbit;
    logic [7:0] rsh;
    assign line       = sync[1];
    assign rx_done[g] = tick && act && (rsub == 4'd7) && (rbit == 4'd9);

    always_ff @(posedge clk)
      if (!rst_n) begin
        sync <= 2'b11; act <= 1'b0; arm <= 1'b0;
        rsub <= '0; rbit <= '0; rsh <= '0;
      end else begin
        sync <= {sync[0], rx[g]};
        if (tick) begin
          if (!act) begin
            if (line) arm <= 1'b1;
            else if (arm) begin
              act <= 1'b1; arm <= 1'b0; rsub <= '0; rbit <= '0;
            end
          end else begin
            rsub <= rsub + 1'b1;
            if (rsub == 4'd15) rbit <= rbit + 1'b1;
            if (rsub == 4'd7) begin
              if (rbit == 4'd0) begin
                if (line) act <= 1'b0;
              end else if (rbit == 4'd9) act <= 1'b0;
              else rsh <= {line, rsh[7:1]};
            end
          end
        end
      end

    logic clr;
    assign clr = rd_clr && (sel == 4'(g));

    always_ff @(posedge clk)
      if (!rst_n) begin
        pend[g] <= 1'b0; ferr[g] <= 1'b0; ovr[g] <= 1'b0; hold[g] <= '0;
      end else if (rx_done[g]) begin
        pend[g] <= 1'b1;
        hold[g] <= rsh;
        ferr[g] <= !line;
        ovr[g]  <= pend[g] && !clr;
      end else if (clr) begin
        pend[g] <= 1'b0;
        ovr[g]  <= 1'b0;
      end
  end

endmodule

// File: rtl/mux_uart_bridge_chk.sv
module mux_uart_bridge_chk #(
  parameter int NCH = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [15:0]    wr_data,
  input logic           rd_en,
  input logic [15:0]    rd_data,
  input logic           irq,
  input logic [NCH-1:0] tx,
  input logic [NCH-1:0] tx_busy,
  input logic [NCH-1:0] pend,
  input logic [NCH-1:0] rx_done,
  input logic           busy_err
);

  p_tx_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (int'(wr_data[11:8]) < NCH) && !tx_busy[wr_data[11:8]]
    |=> !tx[$past(wr_data[11:8])]);

  p_bad_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (int'(wr_data[11:8]) >= NCH) && (tx_busy == '0)
    |=> (tx_busy == '0) && (tx == '1));

  p_busy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (int'(wr_data[11:8]) < NCH) && tx_busy[wr_data[11:8]]
    |=> busy_err && rd_data[14]);

  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && irq && ($countones(pend) == 1) && (rx_done == '0)
    |=> !irq);

  p_irq_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int'(rd_data[11:8]) < NCH) && pend[rd_data[11:8]]);

endmodule

bind mux_uart_bridge mux_uart_bridge_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .tx(tx),
  .tx_busy(tx_busy), .pend(pend), .rx_done(rx_done), .busy_err(busy_err)
);

// File: tb/sim_mux_uart_bridge.sv
module sim_mux_uart_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] os_div = 16'd1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;
  logic [NCH-1:0] rx = '1;
  logic [NCH-1:0] tx;

  int checks = 0, errors = 0, bitclk = 32;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_uart_bridge #(.NCH(NCH), .DIVW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .os_div(os_div), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .rx(rx), .tx(tx));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic host_write(input logic [15:0] w);
    @(negedge clk); wr_data = w; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_tx(input int ch, input logic [7:0] b, input int first, input string req);
    logic [9:0] f;
    logic [NCH-1:0] exp;
    f = {1'b1, b, 1'b0};
    wait_clk(first);
    for (int k = 0; k < 10; k++) begin
      exp = '1; exp[ch] = f[k];
      chk(tx == exp, req, int'(tx), int'(exp));
      wait_clk(bitclk);
    end
  endtask

  task automatic drive_rx(input int ch, input logic [7:0] b, input logic stopb);
    logic [9:0] f;
    f = {stopb, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      rx[ch] = f[k];
      wait_clk(bitclk);
    end
    rx[ch] = 1'b1;
  endtask

  task automatic expect_word(input int ch, input logic [7:0] b, input logic fe,
                             input logic ov, input string req);
    logic [15:0] e;
    e = {1'b0, 1'b0, ov, fe, 4'(ch), b};
    chk(irq == 1'b1, req, int'(irq), 1);
    chk(rd_data == e, req, int'(rd_data), int'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    // R1 reset state
    chk(tx == '1, "R1 tx", int'(tx), 'h3ff);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    chk(rd_data[14] == 1'b0, "R1 busy-err", int'(rd_data[14]), 0);

    // R2 sweep of every channel
    for (int c = 0; c < NCH; c++) begin
      logic [7:0] b;
      b = 8'(c * 29 + 7);
      host_write({4'h0, 4'(c), b});
      check_tx(c, b, 16, "R2");
      wait_clk(bitclk);
    end

    // R3 out-of-range indices
    for (int c = NCH; c < 16; c++) begin
      host_write({4'h0, 4'(c), 8'h00});
      wait_clk(20);
      chk(tx == '1, "R3 tx", int'(tx), 'h3ff);
      chk(rd_data[14] == 1'b0, "R3 busy-err", int'(rd_data[14]), 0);
    end

    // R4 write to a busy channel
    host_write(16'h03A5);
    host_write(16'h033C);
    chk(rd_data[14] == 1'b1, "R4 sticky", int'(rd_data[14]), 1);
    check_tx(3, 8'hA5, 14, "R4 frame kept");
    wait_clk(bitclk);
    host_read();
    chk(rd_data[14] == 1'b0, "R4 cleared", int'(rd_data[14]), 0);

    // R6 R7 receive sweep on every channel
    for (int c = 0; c < NCH; c++) begin
      logic [7:0] b;
      b = 8'(c * 53 + 17);
      drive_rx(c, b, 1'b1);
      wait_clk(8);
      expect_word(c, b, 1'b0, 1'b0, "R6");
      host_read();
      chk(irq == 1'b0, "R7 cleared", int'(irq), 0);
      wait_clk(bitclk);
    end

    // R6 boundary data patterns
    drive_rx(4, 8'h00, 1'b1); wait_clk(8);
    expect_word(4, 8'h00, 1'b0, 1'b0, "R6 zeros"); host_read();
    drive_rx(9, 8'hFF, 1'b1); wait_clk(8);
    expect_word(9, 8'hFF, 1'b0, 1'b0, "R6 ones"); host_read();
    wait_clk(bitclk);

    // R8 priority with two pending
    fork
      drive_rx(7, 8'h71, 1'b1);
      drive_rx(2, 8'h22, 1'b1);
    join
    wait_clk(8);
    expect_word(2, 8'h22, 1'b0, 1'b0, "R8 first");
    host_read();
    expect_word(7, 8'h71, 1'b0, 1'b0, "R8 second");
    host_read();
    chk(irq == 1'b0, "R7 all read", int'(irq), 0);
    wait_clk(bitclk);

    // R9 framing error, then line high again and a good frame
    drive_rx(1, 8'h5C, 1'b0);
    wait_clk(8);
    expect_word(1, 8'h5C, 1'b1, 1'b0, "R9 flag");
    host_read();
    wait_clk(2 * bitclk);
    chk(irq == 1'b0, "R9 no spurious", int'(irq), 0);
    drive_rx(1, 8'h3E, 1'b1); wait_clk(8);
    expect_word(1, 8'h3E, 1'b0, 1'b0, "R9 recover"); host_read();
    wait_clk(bitclk);

    // R10 overrun keeps the newest character
    drive_rx(5, 8'h11, 1'b1);
    drive_rx(5, 8'h99, 1'b1);
    wait_clk(8);
    expect_word(5, 8'h99, 1'b0, 1'b1, "R10");
    host_read();
    chk(irq == 1'b0, "R10 cleared", int'(irq), 0);
    wait_clk(bitclk);

    // R11 short glitch rejected
    rx[6] = 1'b0; wait_clk(8); rx[6] = 1'b1;
    wait_clk(12 * bitclk);
    chk(irq == 1'b0, "R11 glitch", int'(irq), 0);

    // R5 slower divider on both directions
    os_div = 16'd3; bitclk = 64;
    wait_clk(8);
    host_write(16'h08C3);
    check_tx(8, 8'hC3, 32, "R5 tx");
    wait_clk(bitclk);
    drive_rx(0, 8'h4B, 1'b1); wait_clk(16);
    expect_word(0, 8'h4B, 1'b0, 1'b0, "R5 rx"); host_read();

    finish_run();
  end
endmodule